// File: doc/BRIEF.md
# Byte-Serial Memory-Operand Addressing Decoder

This block sits behind an instruction length and prefix stage. It takes the operand-addressing bytes of one instruction one per clock, starting with the ModRM byte. It works out from each byte whether another byte belongs to the operand: a scale/index/base (SIB) byte, or one to four displacement bytes. When the last byte has been taken, it presents a complete operand description for one cycle.

That description covers the following:
- whether the operand is a register or memory;
- the 4-bit register-field number;
- the register selected in the direct form;
- the base (none, a general register, or the instruction pointer);
- the index register and scale;
- the displacement, sign-extended to 64 bits;
- the total number of bytes the operand occupies.

The three register-extension bits and the address width (16, 32 or 64 bit) are presented with the ModRM byte and sampled only in that cycle.

The controller has four states. `ST_MODRM` waits for the ModRM byte. It moves to `ST_SIB` when a SIB byte follows, to `ST_DISP` when displacement bytes follow, and otherwise to `ST_REPORT`. `ST_SIB` takes one byte and moves to `ST_DISP` or `ST_REPORT`. `ST_DISP` counts displacement bytes and moves to `ST_REPORT` on the last one. `ST_REPORT` shows the result for one cycle with `in_ready` low and always returns to `ST_MODRM`.

Top module: `modrm_addr_decoder`

## Requirements
- R1: The ModRM byte is split as mode = bits 7:6, register field = bits 5:3, r/m = bits 2:0. `reg_num` = {ext_r, register field} in every address width. `ext_r`, `ext_x`, `ext_b` and `addr_mode` are sampled only with the ModRM byte; their later values have no effect. `addr_mode` encoding: 00 = 16-bit, 01 = 32-bit, 1x = 64-bit.
- R2: Mode 11 is a register operand. `is_mem`=0, `rm_reg` = {ext_b, r/m}, `base_kind`=none, `index_valid`=0, `disp`=0, `byte_count`=1. `rm_reg` = {ext_b, r/m} is also reported for memory forms.
- R3: In 32/64-bit width with a memory mode and r/m not 100 (and not the case of R4), `base_kind`=general (code 1) and `base_reg` = {ext_b, r/m`}`. Mode 01 adds one displacement byte; mode 10 adds four.
- R4: In 32/64-bit width, mode 00 with r/m 101 carries four displacement bytes. The base is none (code 0) in 32-bit width and the instruction pointer (code 2) in 64-bit width. There is no index.
- R5: In 32/64-bit width, r/m 100 with a memory mode means the next byte is a SIB byte. From it, `scale` = bits 7:6 (multiplier 2^scale) and `index_reg` = {ext_x, bits 5:3}. An index value of 0100 gives `index_valid`=0 and `index_reg`=0.
- R6: A SIB base field (bits 2:0) of 101 with mode 00 gives base none and four displacement bytes, whatever `ext_b` is. Any other SIB base gives `base_reg` = {ext_b, base field}, with displacement taken from the mode as in R3.
- R7: In 16-bit width, memory r/m 0..7 give (base, index): (BX,SI), (BX,DI), (BP,SI), (BP,DI), (SI,–), (DI,–), (BP,–), (BX,–). Register numbers are BX=3, BP=5, SI=6, DI=7. `ext_b` and `ext_x` do not affect these, no SIB byte is taken, and `scale`=0.
- R8: In 16-bit width, mode 01 adds one displacement byte and mode 10 adds two. Mode 00 with r/m 110 means no base, no index and two displacement bytes.
- R9: Displacement bytes are assembled least significant first and sign-extended from the top received byte to 64 bits.
- R10: `done` is high for exactly one cycle: the cycle after the last operand byte is accepted. `byte_count` = 1 + (1 if a SIB byte was taken) + number of displacement bytes. `done` is low while bytes are still due.
- R11: `in_ready` is high out of reset and in every state except the report cycle. A byte offered during the report cycle is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | `in_byte` holds an operand byte |
| in_byte | input | 8 | ModRM, SIB or displacement byte |
| ext_r | input | 1 | Register-field extension bit |
| ext_x | input | 1 | Index extension bit |
| ext_b | input | 1 | r/m and base extension bit |
| addr_mode | input | 2 | Address width: 00=16, 01=32, 1x=64 |
| in_ready | output | 1 | A byte is accepted this cycle if valid |
| done | output | 1 | Operand description valid (one cycle) |
| is_mem | output | 1 | 1 = memory operand, 0 = register operand |
| reg_num | output | 4 | Extended register field |
| rm_reg | output | 4 | Extended r/m register number |
| base_kind | output | 2 | 0 none, 1 general register, 2 instruction pointer |
| base_reg | output | 4 | Base register number (0 when not general) |
| index_valid | output | 1 | An index register is used |
| index_reg | output | 4 | Index register number (0 when unused) |
| scale | output | 2 | Index multiplier exponent |
| disp | output | 64 | Sign-extended displacement |
| byte_count | output | 3 | Bytes occupied by ModRM, SIB and displacement |

## Verification
All 256 ModRM values are driven in each of the three address widths, so every mode and r/m pairing is seen under each width. This separates the 16-bit combination table from the 32/64-bit forms, and the 32-bit bare displacement from the 64-bit instruction-pointer form.

A second sweep drives all 256 SIB values behind each of the three memory modes in 32- and 64-bit width. The extension bits vary as it goes, which shows:
- the no-index code;
- the base-none escape, taken on the unextended field;
- how the mode sets the displacement length.

Extension and width inputs are inverted after the ModRM byte to show that they are sampled only once. Displacement bytes come from a varying seed, so both signs occur at every length. A stray byte is offered during a report cycle to show that it is refused.

// File: rtl/modrm_dec_pkg.sv
package modrm_dec_pkg;

    localparam int REG_W = 4;

    localparam logic [REG_W-1:0] GPR_BX       = 4'd3;
    localparam logic [REG_W-1:0] GPR_BP       = 4'd5;
    localparam logic [REG_W-1:0] GPR_SI       = 4'd6;
    localparam logic [REG_W-1:0] GPR_DI       = 4'd7;
    localparam logic [REG_W-1:0] GPR_NO_INDEX = 4'd4;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_GPR  = 2'd1,
        BASE_IP   = 2'd2
    } base_kind_e;

    typedef enum logic [1:0] {
        ST_MODRM  = 2'd0,
        ST_SIB    = 2'd1,
        ST_DISP   = 2'd2,
        ST_REPORT = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic             is_mem;
        logic [REG_W-1:0] reg_num;
        logic [REG_W-1:0] rm_reg;
        base_kind_e       base_kind;
        logic [REG_W-1:0] base_reg;
        logic             index_valid;
        logic [REG_W-1:0] index_reg;
        logic [1:0]       scale;
    } operand_t;

endpackage

// File: rtl/modrm_classify.sv
module modrm_classify
    import modrm_dec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [7:0]       modrm_i,
    input  logic             ext_r_i,
    input  logic             ext_b_i,
    input  logic             aw16_i,
    input  logic             aw64_i,
    output operand_t         op_o,
    output logic             sib_next_o,
    output logic [LEN_W-1:0] disp_len_o
);

    logic [1:0] mode_f;
    logic [2:0] reg_f;
    logic [2:0] rm_f;

    assign mode_f = modrm_i[7:6];
    assign reg_f  = modrm_i[5:3];
    assign rm_f   = modrm_i[2:0];

    always_comb begin
        op_o           = '0;
        op_o.is_mem    = (mode_f != 2'b11);
        op_o.reg_num   = {ext_r_i, reg_f};
        op_o.rm_reg    = {ext_b_i, rm_f};
        op_o.base_kind = BASE_NONE;
        sib_next_o     = 1'b0;
        disp_len_o     = '0;
        if (op_o.is_mem) begin
            if (aw16_i) begin
                // fixed pairing table of the 16-bit forms
                op_o.base_kind = BASE_GPR;
                unique case (rm_f)
                    3'd0: begin op_o.base_reg = GPR_BX; op_o.index_reg = GPR_SI; op_o.index_valid = 1'b1; end
                    3'd1: begin op_o.base_reg = GPR_BX; op_o.index_reg = GPR_DI; op_o.index_valid = 1'b1; end
                    3'd2: begin op_o.base_reg = GPR_BP; op_o.index_reg = GPR_SI; op_o.index_valid = 1'b1; end
                    3'd3: begin op_o.base_reg = GPR_BP; op_o.index_reg = GPR_DI; op_o.index_valid = 1'b1; end
                    3'd4: op_o.base_reg = GPR_SI;
                    3'd5: op_o.base_reg = GPR_DI;
                    3'd6: op_o.base_reg = GPR_BP;
                    3'd7: op_o.base_reg = GPR_BX;
                endcase
                if (mode_f == 2'b01) begin
                    disp_len_o = LEN_W'(1);
                end else if (mode_f == 2'b10) begin
                    disp_len_o = LEN_W'(2);
                end else if (rm_f == 3'b110) begin
                    disp_len_o     = LEN_W'(2);
                    op_o.base_kind = BASE_NONE;
                    op_o.base_reg  = '0;
                end
            end else begin
                if (mode_f == 2'b01) begin
                    disp_len_o = LEN_W'(1);
                end else if (mode_f == 2'b10) begin
                    disp_len_o = LEN_W'(4);
                end
                if (rm_f == 3'b100) begin
                    sib_next_o = 1'b1;
                end else if (mode_f == 2'b00 && rm_f == 3'b101) begin
                    disp_len_o = LEN_W'(4);
                    if (aw64_i) begin
                        op_o.base_kind = BASE_IP;
                    end else begin
                        op_o.base_kind = BASE_NONE;
                    end
                end else begin
                    op_o.base_kind = BASE_GPR;
                    op_o.base_reg  = {ext_b_i, rm_f};
                end
            end
        end
    end

endmodule

// File: rtl/sib_classify.sv
module sib_classify
    import modrm_dec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [7:0]       sib_i,
    input  logic [1:0]       mode_i,
    input  logic             ext_x_i,
    input  logic             ext_b_i,
    output base_kind_e       base_kind_o,
    output logic [REG_W-1:0] base_reg_o,
    output logic             index_valid_o,
    output logic [REG_W-1:0] index_reg_o,
    output logic [1:0]       scale_o,
    output logic [LEN_W-1:0] disp_len_o
);

    logic [REG_W-1:0] idx_ext;

    assign idx_ext       = {ext_x_i, sib_i[5:3]};
    assign index_valid_o = (idx_ext != GPR_NO_INDEX);
    assign index_reg_o   = index_valid_o ? idx_ext : '0;
    assign scale_o       = sib_i[7:6];

    always_comb begin
        // escape decided on the raw 3-bit field, extension bit not consulted
        if (mode_i == 2'b00 && sib_i[2:0] == 3'b101) begin
            base_kind_o = BASE_NONE;
            base_reg_o  = '0;
            disp_len_o  = LEN_W'(4);
        end else begin
            base_kind_o = BASE_GPR;
            base_reg_o  = {ext_b_i, sib_i[2:0]};
            if (mode_i == 2'b01) begin
                disp_len_o = LEN_W'(1);
            end else if (mode_i == 2'b10) begin
                disp_len_o = LEN_W'(4);
            end else begin
                disp_len_o = '0;
            end
        end
    end

endmodule

// File: rtl/disp_collect.sv
module disp_collect #(
    parameter int MAX_BYTES = 4,
    parameter int OUT_W     = 64,
    parameter int LEN_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] lane_i,
    input  logic [7:0]       byte_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [OUT_W-1:0] disp_o
);

    logic [7:0] lanes [MAX_BYTES];

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lanes[g] <= '0;
            end else if (clear_i) begin
                lanes[g] <= '0;
            end else if (load_i && lane_i == LEN_W'(g)) begin
                lanes[g] <= byte_i;
            end
        end
    end

    logic sign_bit;

    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (LEN_W'(i) < len_i) begin
                sign_bit = lanes[i][7];
            end
        end
        disp_o = {OUT_W{sign_bit}};
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (LEN_W'(i) < len_i) begin
                disp_o[8*i +: 8] = lanes[i];
            end
        end
    end

endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
    import modrm_dec_pkg::*;
#(
    parameter int  DISP_W         = 64,
    parameter int  MAX_DISP_BYTES = 4,
    localparam int CNT_W          = $clog2(MAX_DISP_BYTES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    input  logic [1:0]        addr_mode,
    output logic              in_ready,
    output logic              done,
    output logic              is_mem,
    output logic [3:0]        reg_num,
    output logic [3:0]        rm_reg,
    output logic [1:0]        base_kind,
    output logic [3:0]        base_reg,
    output logic              index_valid,
    output logic [3:0]        index_reg,
    output logic [1:0]        scale,
    output logic [DISP_W-1:0] disp,
    output logic [CNT_W-1:0]  byte_count
);

    localparam int LEN_W = $clog2(MAX_DISP_BYTES + 1);

    dec_state_e       state_q, state_d;
    operand_t         op_q;
    logic [LEN_W-1:0] dlen_q;
    logic [LEN_W-1:0] dcnt_q;
    logic             sib_q;
    logic [1:0]       mode_q;
    logic             ext_x_q;
    logic             ext_b_q;
    logic             accept;

    // ModRM stage
    operand_t         m_op;
    logic             m_sib;
    logic [LEN_W-1:0] m_len;

    modrm_classify #(.LEN_W(LEN_W)) u_modrm (
        .modrm_i    (in_byte),
        .ext_r_i    (ext_r),
        .ext_b_i    (ext_b),
        .aw16_i     (addr_mode == 2'b00),
        .aw64_i     (addr_mode[1]),
        .op_o       (m_op),
        .sib_next_o (m_sib),
        .disp_len_o (m_len)
    );

    // SIB stage, fed with the fields latched at ModRM time
    base_kind_e       s_bk;
    logic [3:0]       s_base;
    logic             s_iv;
    logic [3:0]       s_idx;
    logic [1:0]       s_scale;
    logic [LEN_W-1:0] s_len;

    sib_classify #(.LEN_W(LEN_W)) u_sib (
        .sib_i         (in_byte),
        .mode_i        (mode_q),
        .ext_x_i       (ext_x_q),
        .ext_b_i       (ext_b_q),
        .base_kind_o   (s_bk),
        .base_reg_o    (s_base),
        .index_valid_o (s_iv),
        .index_reg_o   (s_idx),
        .scale_o       (s_scale),
        .disp_len_o    (s_len)
    );

    disp_collect #(
        .MAX_BYTES (MAX_DISP_BYTES),
        .OUT_W     (DISP_W),
        .LEN_W     (LEN_W)
    ) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_MODRM && accept),
        .load_i  (state_q == ST_DISP && accept),
        .lane_i  (dcnt_q),
        .byte_i  (in_byte),
        .len_i   (dlen_q),
        .disp_o  (disp)
    );

    assign accept = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MODRM;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MODRM: begin
                if (accept) begin
                    if (m_sib) begin
                        state_d = ST_SIB;
                    end else if (m_len != '0) begin
                        state_d = ST_DISP;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_SIB: begin
                if (accept) begin
                    state_d = (s_len != '0) ? ST_DISP : ST_REPORT;
                end
            end
            ST_DISP: begin
                if (accept && dcnt_q == dlen_q - LEN_W'(1)) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: state_d = ST_MODRM;
        endcase
    end

    // outputs
    always_comb begin
        done     = 1'b0;
        in_ready = 1'b1;
        unique case (state_q)
            ST_REPORT: begin
                done     = 1'b1;
                in_ready = 1'b0;
            end
            default: ;
        endcase
    end

    // operand data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            dlen_q  <= '0;
            dcnt_q  <= '0;
            sib_q   <= 1'b0;
            mode_q  <= '0;
            ext_x_q <= 1'b0;
            ext_b_q <= 1'b0;
        end else if (accept) begin
            if (state_q == ST_MODRM) begin
                op_q    <= m_op;
                dlen_q  <= m_len;
                dcnt_q  <= '0;
                sib_q   <= m_sib;
                mode_q  <= in_byte[7:6];
                ext_x_q <= ext_x;
                ext_b_q <= ext_b;
            end else if (state_q == ST_SIB) begin
                op_q.base_kind   <= s_bk;
                op_q.base_reg    <= s_base;
                op_q.index_valid <= s_iv;
                op_q.index_reg   <= s_idx;
                op_q.scale       <= s_scale;
                dlen_q           <= s_len;
            end else if (state_q == ST_DISP) begin
                dcnt_q <= dcnt_q + LEN_W'(1);
            end
        end
    end

    assign is_mem      = op_q.is_mem;
    assign reg_num     = op_q.reg_num;
    assign rm_reg      = op_q.rm_reg;
    assign base_kind   = op_q.base_kind;
    assign base_reg    = op_q.base_reg;
    assign index_valid = op_q.index_valid;
    assign index_reg   = op_q.index_reg;
    assign scale       = op_q.scale;
    assign byte_count  = CNT_W'(1) + CNT_W'(sib_q) + CNT_W'(dlen_q);

endmodule

// File: rtl/modrm_addr_decoder_checker.sv
module modrm_addr_decoder_checker #(
    parameter int DISP_W = 64,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              done,
    input logic              is_mem,
    input logic [1:0]        base_kind,
    input logic              index_valid,
    input logic [3:0]        index_reg,
    input logic [DISP_W-1:0] disp,
    input logic [CNT_W-1:0]  byte_count
);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready));

    a_r10_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count >= CNT_W'(1) && byte_count <= CNT_W'(6)));

    a_r2_direct_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_mem) |-> (base_kind == 2'd0 && !index_valid
                               && byte_count == CNT_W'(1) && disp == '0));

    a_r4_ip_form: assert property (@(posedge clk) disable iff (!rst_n)
        (done && base_kind == 2'd2) |-> (!index_valid && byte_count == CNT_W'(5)));

    a_r5_no_index_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && index_valid) |-> (index_reg != 4'd4));

    a_r11_ready_after_report: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

endmodule

bind modrm_addr_decoder modrm_addr_decoder_checker #(
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/modrm_addr_decoder_test.sv
module modrm_addr_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        ext_r, ext_x, ext_b;
    logic [1:0]  addr_mode;
    logic        in_ready, done, is_mem, index_valid;
    logic [3:0]  reg_num, rm_reg, base_reg, index_reg;
    logic [1:0]  base_kind, scale;
    logic [63:0] disp;
    logic [2:0]  byte_count;

    int n_vec = 0;
    int n_bad = 0;

    modrm_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b), .addr_mode(addr_mode),
        .in_ready(in_ready), .done(done), .is_mem(is_mem), .reg_num(reg_num),
        .rm_reg(rm_reg), .base_kind(base_kind), .base_reg(base_reg),
        .index_valid(index_valid), .index_reg(index_reg), .scale(scale),
        .disp(disp), .byte_count(byte_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R10 watchdog actual=hang expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic run_tx(input logic [1:0] mode, input logic [2:0] rxb,
                          input logic [7:0] mrm, input logic [7:0] sb,
                          input logic [7:0] seed, input bit stray);
        logic [1:0]  md;
        logic [2:0]  rm;
        logic        e_mem, e_iv, nsib;
        logic [3:0]  e_base, e_idx;
        logic [1:0]  e_bk, e_sc;
        int          dl;
        logic [7:0]  d [4];
        logic [63:0] e_disp;
        md = mrm[7:6];
        rm = mrm[2:0];
        e_mem = (md != 2'b11);
        e_bk = 2'd0; e_base = 4'd0; e_iv = 1'b0; e_idx = 4'd0; e_sc = 2'd0;
        nsib = 1'b0; dl = 0;
        if (e_mem) begin
            if (mode == 2'b00) begin
                e_bk = 2'd1;
                case (rm)
                    3'd0: begin e_base = 4'd3; e_idx = 4'd6; e_iv = 1'b1; end
                    3'd1: begin e_base = 4'd3; e_idx = 4'd7; e_iv = 1'b1; end
                    3'd2: begin e_base = 4'd5; e_idx = 4'd6; e_iv = 1'b1; end
                    3'd3: begin e_base = 4'd5; e_idx = 4'd7; e_iv = 1'b1; end
                    3'd4: e_base = 4'd6;
                    3'd5: e_base = 4'd7;
                    3'd6: e_base = 4'd5;
                    default: e_base = 4'd3;
                endcase
                dl = (md == 2'b01) ? 1 : (md == 2'b10) ? 2 : 0;
                if (md == 2'b00 && rm == 3'd6) begin
                    e_bk = 2'd0; e_base = 4'd0; dl = 2;
                end
            end else begin
                dl = (md == 2'b01) ? 1 : (md == 2'b10) ? 4 : 0;
                if (rm == 3'd4) begin
                    nsib = 1'b1;
                    e_sc = sb[7:6];
                    e_idx = {rxb[1], sb[5:3]};
                    e_iv = (e_idx != 4'd4);
                    if (!e_iv) e_idx = 4'd0;
                    if (md == 2'b00 && sb[2:0] == 3'd5) begin
                        dl = 4;
                    end else begin
                        e_bk = 2'd1; e_base = {rxb[0], sb[2:0]};
                    end
                end else if (md == 2'b00 && rm == 3'd5) begin
                    e_bk = mode[1] ? 2'd2 : 2'd0; dl = 4;
                end else begin
                    e_bk = 2'd1; e_base = {rxb[0], rm};
                end
            end
        end
        e_disp = 64'd0;
        for (int i = 0; i < 4; i++) d[i] = (seed ^ (8'(i) * 8'h6D)) + 8'(i);
        for (int i = 0; i < dl; i++) e_disp[8*i +: 8] = d[i];
        if (dl > 0 && d[dl-1][7]) begin
            for (int j = 8*dl; j < 64; j++) e_disp[j] = 1'b1;
        end

        addr_mode = mode;
        {ext_r, ext_x, ext_b} = rxb;
        in_valid = 1'b1;
        in_byte = mrm;
        @(negedge clk);
        // R1: later changes of the sampled inputs must have no effect
        {ext_r, ext_x, ext_b} = ~rxb;
        addr_mode = ~mode;
        if (nsib) begin
            chk("R10 done before SIB", {63'd0, done}, 64'd0);
            in_byte = sb;
            @(negedge clk);
        end
        for (int i = 0; i < dl; i++) begin
            chk("R10 done before disp byte", {63'd0, done}, 64'd0);
            in_byte = d[i];
            @(negedge clk);
        end
        if (stray) begin
            in_valid = 1'b1;
            in_byte = 8'h05;
        end else begin
            in_valid = 1'b0;
        end
        chk("R10 done", {63'd0, done}, 64'd1);
        chk("R2 is_mem", {63'd0, is_mem}, {63'd0, e_mem});
        chk("R1 reg_num", {60'd0, reg_num}, {60'd0, rxb[2], mrm[5:3]});
        chk("R2 rm_reg", {60'd0, rm_reg}, {60'd0, rxb[0], rm});
        chk("R3 R4 R6 R7 base_kind", {62'd0, base_kind}, {62'd0, e_bk});
        chk("R3 R6 R7 base_reg", {60'd0, base_reg}, {60'd0, e_base});
        chk("R5 R7 index_valid", {63'd0, index_valid}, {63'd0, e_iv});
        chk("R5 R7 index_reg", {60'd0, index_reg}, {60'd0, e_idx});
        chk("R5 scale", {62'd0, scale}, {62'd0, e_sc});
        chk("R9 R8 disp", disp, e_disp);
        chk("R10 byte_count", {61'd0, byte_count}, 64'(1 + int'(nsib) + dl));
        chk("R11 ready low in report", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 done is one cycle", {63'd0, done}, 64'd0);
        chk("R11 ready after report", {63'd0, in_ready}, 64'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_byte = 8'd0;
        {ext_r, ext_x, ext_b} = 3'b000;
        addr_mode = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset ready", {63'd0, in_ready}, 64'd1);
        chk("R10 reset done", {63'd0, done}, 64'd0);

        // all ModRM values in each width
        for (int mode = 0; mode < 3; mode++) begin
            for (int m = 0; m < 256; m++) begin
                run_tx(2'(mode), 3'((m ^ (m >> 3)) + mode), 8'(m),
                       8'(m * 7 + mode * 29), 8'(m * 13 + mode), 1'b0);
            end
        end

        // all SIB values behind each memory mode (R5 R6)
        for (int mode = 1; mode < 3; mode++) begin
            for (int md = 0; md < 3; md++) begin
                for (int s = 0; s < 256; s++) begin
                    run_tx(2'(mode), 3'(s ^ (s >> 5) ^ md), {2'(md), 3'(s), 3'b100},
                           8'(s), 8'(s * 3 + md * 71), 1'b0);
                end
            end
        end

        // R11: byte offered during report is refused, then normal decode resumes
        run_tx(2'b10, 3'b101, 8'h84, 8'h65, 8'h91, 1'b1);
        run_tx(2'b10, 3'b111, 8'hD8, 8'h00, 8'h00, 1'b0);
        run_tx(2'b01, 3'b000, 8'h45, 8'h00, 8'h80, 1'b1);
        run_tx(2'b00, 3'b011, 8'h86, 8'h00, 8'hF0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule